// File: doc/BRIEF.md
# Daisy-Chained Priority Interrupt Controller

This block arbitrates interrupt requests from many devices spread over a small number of priority levels. Each level has one shared request line, the wired OR of every device requesting at that level. When the highest pending level outranks the running processor priority, the controller drives that level's grant into a serial chain of device cells. The grant enters at the cell nearest the processor. It stops at the first cell that is requesting and passes through every cell that is not. The cell that keeps the grant answers with its vector address.

The controller then reads two words through a simple memory port: the new program counter from the vector address and the new status word from the vector address plus 2. If no cell answers within a fixed number of cycles, it abandons the grant and loads from a fixed spurious-interrupt vector instead. Requests are level-held by the devices until software clears them, so an unserviced request is simply seen again in the next round.

The controller is a five-state machine. IDLE leaves to WAIT_ACK on *arbitrate* (a pending level outranks the processor). WAIT_ACK leaves to LOAD_PC on *answer* (a cell took the grant) or on *expire* (the timeout ran out). LOAD_PC goes to LOAD_PS on *next word*, LOAD_PS goes to DONE on *loaded*, and DONE returns to IDLE on *release*.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, no grant is driven, no memory read is issued and the completion pulse is low, even if requests are pending.
- R2: Level index k (0 to NLVL-1) carries priority BASE_PRI+k. A grant is issued only when that priority is strictly greater than `cpu_pri`; with a request at equal or lower priority, no grant appears.
- R3: When several levels are pending, the grant goes to the highest level index, at most one grant line is high at a time, and the grant never switches directly from one level to another.
- R4: Within a level, device index 0 is nearest the processor. The lowest-index requesting device takes the grant, and at most one device acknowledge is high.
- R5: The load uses the answering device's vector with bit 0 cleared. Two consecutive memory reads go to that address and to that address plus 2. `new_pc` holds the first word and `new_psw` the second. `vec_done` pulses for one cycle in the cycle after the second read.
- R6: A request that is still held after its service is granted and serviced again in a later round.
- R7: If no device answers, the grant stays up for exactly TMO cycles. The load then uses SPUR_VEC, and `spurious` is high together with `vec_done`.
- R8: A cell decides whether to take the grant in the cycle the grant reaches it. A request raised after the grant has passed does not take it, and the grant then shows at `chain_tail`. That request is serviced in the next round.
- R9: The grant line drops in the cycle after a device acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_pri | input | 3 | Current processor priority |
| dev_req | input | NLVL*NDEV | Device requests, bit k*NDEV+d is device d of level k |
| stray_req | input | NLVL | Extra request inputs wired onto each level line, with no vector source |
| dev_vec | input | NLVL*NDEV*VW | Vector of each device, same ordering as dev_req |
| bus_grant | output | NLVL | Grant driven into the head of each level chain |
| dev_ack | output | NLVL*NDEV | Device has taken the grant and drives its vector |
| chain_tail | output | NLVL | Grant emerging unanswered from the end of each chain |
| mem_rd | output | 1 | Vector-block read strobe |
| mem_addr | output | VW | Read address |
| mem_rdata | input | VW | Read data, valid in the cycle of the strobe |
| vec_addr | output | VW | Vector address used by the last load |
| new_pc | output | VW | Loaded program counter |
| new_psw | output | VW | Loaded status word |
| vec_done | output | 1 | One-cycle pulse when both words are loaded |
| spurious | output | 1 | The completed load came from the spurious vector |

## Verification
A wrong level register or priority compare shows on `bus_grant` in the cycle after the inputs change: the grant lands on the wrong line or appears when it must not. A cell that latches its decision incorrectly shows as a stray or missing `dev_ack` while the grant is still up, or as a grant reaching `chain_tail` with a requester behind it. A fault in the timeout counter changes the grant length away from TMO cycles and is visible when the grant drops. Errors in the vector register or word sequencing show three cycles after the answer, in `vec_addr`, `new_pc` and `new_psw` at the `vec_done` pulse.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_WAIT    = 3'd1,
        S_LOAD_PC = 3'd2,
        S_LOAD_PS = 3'd3,
        S_DONE    = 3'd4
    } arb_state_t;
endpackage

// File: rtl/irq_chain_cell.sv
module irq_chain_cell #(
    parameter int VW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [VW-1:0] vec_i,
    input  logic          gin_i,
    output logic          gout_o,
    output logic          ack_o,
    output logic [VW-1:0] vec_o
);
    logic gin_q;
    logic held_q;
    logic take;

    // decision made on grant arrival, then frozen while the grant stays up
    assign take   = gin_i & (gin_q ? held_q : req_i);
    assign gout_o = gin_i & ~take;
    assign ack_o  = take;
    assign vec_o  = take ? vec_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gin_q  <= 1'b0;
            held_q <= 1'b0;
        end else begin
            gin_q <= gin_i;
            if (gin_i && !gin_q)
                held_q <= req_i;
        end
    end
endmodule

// File: rtl/irq_level_chain.sv
module irq_level_chain #(
    parameter int NDEV = 3,
    parameter int VW   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_i,
    input  logic [NDEV-1:0]    req_i,
    input  logic [NDEV*VW-1:0] vec_i,
    output logic [NDEV-1:0]    ack_o,
    output logic [VW-1:0]      vec_o,
    output logic               tail_o,
    output logic               pend_o
);
    logic [NDEV:0]      chain;
    logic [NDEV*VW-1:0] cell_vec;

    assign chain[0] = grant_i;
    assign tail_o   = chain[NDEV];
    assign pend_o   = |req_i;

    for (genvar d = 0; d < NDEV; d++) begin : g_cell
        irq_chain_cell #(.VW(VW)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (req_i[d]),
            .vec_i  (vec_i[d*VW +: VW]),
            .gin_i  (chain[d]),
            .gout_o (chain[d+1]),
            .ack_o  (ack_o[d]),
            .vec_o  (cell_vec[d*VW +: VW])
        );
    end

    always_comb begin
        vec_o = '0;
        for (int d = 0; d < NDEV; d++)
            vec_o = vec_o | cell_vec[d*VW +: VW];
    end
endmodule

// File: rtl/irq_arb_fsm.sv
module irq_arb_fsm
    import irq_daisy_pkg::*;
#(
    parameter int          NLVL     = 4,
    parameter int          VW       = 16,
    parameter int          BASE_PRI = 4,
    parameter int          TMO      = 16,
    parameter logic [15:0] SPUR_VEC = 16'h0004
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      cpu_pri,
    input  logic [NLVL-1:0] lvl_req,
    input  logic            any_ack,
    input  logic [VW-1:0]   ack_vec,
    output logic [NLVL-1:0] grant,
    output logic            mem_rd,
    output logic [VW-1:0]   mem_addr,
    input  logic [VW-1:0]   mem_rdata,
    output logic [VW-1:0]   vec_addr,
    output logic [VW-1:0]   new_pc,
    output logic [VW-1:0]   new_psw,
    output logic            vec_done,
    output logic            spurious
);
    localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1;
    localparam int CW = (TMO > 1) ? $clog2(TMO) : 1;

    arb_state_t      st, st_nx;
    logic [LW-1:0]   top, lvl_q;
    logic            found, go, expire;
    logic [CW-1:0]   cnt_q;
    logic [VW-1:0]   vec_q, pc_q, psw_q;
    logic            spur_q;

    // highest pending level: ascending scan, last hit wins
    always_comb begin
        top   = '0;
        found = 1'b0;
        for (int k = 0; k < NLVL; k++) begin
            if (lvl_req[k]) begin
                top   = LW'(k);
                found = 1'b1;
            end
        end
    end

    assign go     = found && ((BASE_PRI + int'(top)) > int'(cpu_pri));
    assign expire = (cnt_q == CW'(TMO - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (go) st_nx = S_WAIT;
            S_WAIT:    if (any_ack || expire) st_nx = S_LOAD_PC;
            S_LOAD_PC: st_nx = S_LOAD_PS;
            S_LOAD_PS: st_nx = S_DONE;
            S_DONE:    st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            cnt_q  <= '0;
            vec_q  <= '0;
            pc_q   <= '0;
            psw_q  <= '0;
            spur_q <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (go) begin
                    lvl_q  <= top;
                    cnt_q  <= '0;
                    spur_q <= 1'b0;
                end
                S_WAIT: begin
                    if (any_ack) begin
                        vec_q <= {ack_vec[VW-1:1], 1'b0};
                    end else if (expire) begin
                        vec_q  <= VW'(SPUR_VEC);
                        spur_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_LOAD_PC: pc_q  <= mem_rdata;
                S_LOAD_PS: psw_q <= mem_rdata;
                S_DONE:    ;
                default:   ;
            endcase
        end
    end

    always_comb begin
        for (int k = 0; k < NLVL; k++)
            grant[k] = (st == S_WAIT) && (lvl_q == LW'(k));
        mem_rd   = (st == S_LOAD_PC) || (st == S_LOAD_PS);
        mem_addr = (st == S_LOAD_PS) ? vec_q + VW'(2) : vec_q;
        vec_done = (st == S_DONE);
        spurious = (st == S_DONE) && spur_q;
    end

    assign vec_addr = vec_q;
    assign new_pc   = pc_q;
    assign new_psw  = psw_q;
endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl #(
    parameter int          NLVL     = 4,
    parameter int          NDEV     = 3,
    parameter int          VW       = 16,
    parameter int          BASE_PRI = 4,
    parameter int          TMO      = 16,
    parameter logic [15:0] SPUR_VEC = 16'h0004
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              cpu_pri,
    input  logic [NLVL*NDEV-1:0]    dev_req,
    input  logic [NLVL-1:0]         stray_req,
    input  logic [NLVL*NDEV*VW-1:0] dev_vec,
    output logic [NLVL-1:0]         bus_grant,
    output logic [NLVL*NDEV-1:0]    dev_ack,
    output logic [NLVL-1:0]         chain_tail,
    output logic                    mem_rd,
    output logic [VW-1:0]           mem_addr,
    input  logic [VW-1:0]           mem_rdata,
    output logic [VW-1:0]           vec_addr,
    output logic [VW-1:0]           new_pc,
    output logic [VW-1:0]           new_psw,
    output logic                    vec_done,
    output logic                    spurious
);
    localparam int LVW = NDEV * VW;

    logic [NLVL-1:0]    pend;
    logic [NLVL-1:0]    lvl_line;
    logic [NLVL*VW-1:0] lvl_vec;
    logic [VW-1:0]      ack_vec;

    for (genvar k = 0; k < NLVL; k++) begin : g_lvl
        irq_level_chain #(.NDEV(NDEV), .VW(VW)) u_chain (
            .clk     (clk),
            .rst_n   (rst_n),
            .grant_i (bus_grant[k]),
            .req_i   (dev_req[k*NDEV +: NDEV]),
            .vec_i   (dev_vec[k*LVW +: LVW]),
            .ack_o   (dev_ack[k*NDEV +: NDEV]),
            .vec_o   (lvl_vec[k*VW +: VW]),
            .tail_o  (chain_tail[k]),
            .pend_o  (pend[k])
        );
        assign lvl_line[k] = pend[k] | stray_req[k];
    end

    always_comb begin
        ack_vec = '0;
        for (int k = 0; k < NLVL; k++)
            ack_vec = ack_vec | lvl_vec[k*VW +: VW];
    end

    irq_arb_fsm #(
        .NLVL(NLVL), .VW(VW), .BASE_PRI(BASE_PRI), .TMO(TMO), .SPUR_VEC(SPUR_VEC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_pri   (cpu_pri),
        .lvl_req   (lvl_line),
        .any_ack   (|dev_ack),
        .ack_vec   (ack_vec),
        .grant     (bus_grant),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .vec_addr  (vec_addr),
        .new_pc    (new_pc),
        .new_psw   (new_psw),
        .vec_done  (vec_done),
        .spurious  (spurious)
    );
endmodule

// File: rtl/irq_daisy_ctrl_chk.sv
module irq_daisy_ctrl_chk #(
    parameter int NLVL = 4,
    parameter int NDEV = 3,
    parameter int VW   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NLVL-1:0]      bus_grant,
    input logic [NLVL*NDEV-1:0] dev_ack,
    input logic                 mem_rd,
    input logic [VW-1:0]        mem_addr,
    input logic                 vec_done,
    input logic                 spurious
);
    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_grant));

    p_grant_no_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_grant && $past(|bus_grant)) |-> $stable(bus_grant));

    p_ack_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack));

    p_read_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + VW'(2)));

    p_read_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !mem_addr[0]);

    p_done_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done |-> ($past(mem_rd) && !mem_rd));

    p_spur_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spurious |-> vec_done);

    p_grant_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|bus_grant && |dev_ack) |=> !(|bus_grant));
endmodule

bind irq_daisy_ctrl irq_daisy_ctrl_chk #(.NLVL(NLVL), .NDEV(NDEV), .VW(VW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_grant (bus_grant),
    .dev_ack   (dev_ack),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .vec_done  (vec_done),
    .spurious  (spurious)
);

// File: tb/irq_daisy_ctrl_test.sv
module irq_daisy_ctrl_test;
    localparam int          NLVL = 4;
    localparam int          NDEV = 3;
    localparam int          VW   = 16;
    localparam int          TMO  = 16;
    localparam logic [15:0] SPUR = 16'h0004;
    localparam int          ND   = NLVL * NDEV;

    typedef struct packed {
        logic [2:0]  pri;
        logic [11:0] req;
        logic [3:0]  lvl_oh;   // expected grant line, 0 = no grant
        logic [3:0]  idx;      // expected flat device index
    } vec_t;

    localparam vec_t CASES [8] = '{
        '{3'd0, 12'h002, 4'b0001, 4'd1},   // R2 R4 low level, second device
        '{3'd3, 12'h028, 4'b0010, 4'd3},   // R4 nearest of two
        '{3'd0, 12'h111, 4'b0100, 4'd8},   // R3 highest level wins
        '{3'd5, 12'h008, 4'b0000, 4'd0},   // R2 equal priority: no grant
        '{3'd5, 12'h080, 4'b0100, 4'd7},   // R5 odd vector masked
        '{3'd6, 12'h201, 4'b1000, 4'd9},   // R2 R3 only top level outranks
        '{3'd7, 12'h800, 4'b0000, 4'd0},   // R2 nothing outranks 7
        '{3'd0, 12'hE00, 4'b1000, 4'd9}    // R4 all three request
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [2:0]           cpu_pri = '0;
    logic [ND-1:0]        dev_req = '0;
    logic [NLVL-1:0]      stray_req = '0;
    logic [ND*VW-1:0]     dev_vec;
    logic [NLVL-1:0]      bus_grant;
    logic [ND-1:0]        dev_ack;
    logic [NLVL-1:0]      chain_tail;
    logic                 mem_rd;
    logic [VW-1:0]        mem_addr;
    logic [VW-1:0]        mem_rdata;
    logic [VW-1:0]        vec_addr, new_pc, new_psw;
    logic                 vec_done, spurious;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    function automatic logic [15:0] mem_f(input logic [15:0] a);
        return a ^ 16'hC3A5;
    endfunction

    function automatic logic [15:0] dvec(input int i);
        return 16'h0100 + 16'(i * 4);
    endfunction

    assign mem_rdata = mem_f(mem_addr);

    initial begin
        for (int i = 0; i < ND; i++)
            dev_vec[i*VW +: VW] = dvec(i) | ((i == 7) ? 16'h0001 : 16'h0000);
    end

    irq_daisy_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_pri(cpu_pri), .dev_req(dev_req),
        .stray_req(stray_req), .dev_vec(dev_vec), .bus_grant(bus_grant),
        .dev_ack(dev_ack), .chain_tail(chain_tail), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .vec_addr(vec_addr),
        .new_pc(new_pc), .new_psw(new_psw), .vec_done(vec_done),
        .spurious(spurious)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watches one arbitration round at falling edges until vec_done or limit.
    task automatic run_round(input int limit, output logic [ND-1:0] ack_seen,
                             output logic [NLVL-1:0] gr_seen, output int gcyc,
                             output logic done, output logic drop_bad);
        logic prev_ack;
        ack_seen = '0; gr_seen = '0; gcyc = 0; done = 1'b0; drop_bad = 1'b0;
        prev_ack = 1'b0;
        for (int c = 0; c < limit; c++) begin
            @(negedge clk);
            if (prev_ack && bus_grant != '0) drop_bad = 1'b1;
            prev_ack = |dev_ack;
            ack_seen = ack_seen | dev_ack;
            gr_seen  = gr_seen | bus_grant;
            if (bus_grant != '0) gcyc++;
            if (vec_done) begin
                done = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [ND-1:0]   ack;
        logic [NLVL-1:0] gr;
        int              gc;
        logic            dn, db;
        logic [15:0]     ev;

        // R1: requests pending during reset
        dev_req = '1;
        repeat (3) @(negedge clk);
        chk("R1 grant in reset", 32'(bus_grant), 32'h0);
        chk("R1 read in reset", 32'(mem_rd), 32'h0);
        dev_req = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant after reset", 32'(bus_grant), 32'h0);
        chk("R1 done after reset", 32'(vec_done), 32'h0);

        // table of arbitration cases
        for (int v = 0; v < 8; v++) begin
            cpu_pri = CASES[v].pri;
            dev_req = CASES[v].req;
            run_round(30, ack, gr, gc, dn, db);
            chk($sformatf("R2 R3 grant line case %0d", v), 32'(gr), 32'(CASES[v].lvl_oh));
            if (CASES[v].lvl_oh == '0) begin
                chk($sformatf("R2 no load case %0d", v), 32'(dn), 32'h0);
            end else begin
                ev = dvec(int'(CASES[v].idx));
                chk($sformatf("R4 ack case %0d", v), 32'(ack), 32'(12'h001 << CASES[v].idx));
                chk($sformatf("R5 vector case %0d", v), 32'(vec_addr), 32'(ev));
                chk($sformatf("R5 pc case %0d", v), 32'(new_pc), 32'(mem_f(ev)));
                chk($sformatf("R5 psw case %0d", v), 32'(new_psw), 32'(mem_f(ev + 16'd2)));
                chk($sformatf("R9 grant drop case %0d", v), 32'(db), 32'h0);
                chk($sformatf("R7 not spurious case %0d", v), 32'(spurious), 32'h0);
            end
            dev_req = '0;
            @(negedge clk);
            chk($sformatf("R5 done one cycle case %0d", v), 32'(vec_done), 32'h0);
            repeat (2) @(negedge clk);
        end

        // R7 R8: stray request on level 2, late requester on device 7
        cpu_pri   = 3'd0;
        stray_req = 4'b0100;
        ack = '0; gc = 0; dn = 1'b0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            ack = ack | dev_ack;
            if (bus_grant != '0) begin
                gc++;
                if (gc == 4) dev_req[7] = 1'b1;
                if (gc == 6) chk("R8 grant reaches tail", 32'(chain_tail), 32'h4);
            end
            if (vec_done) begin
                dn = 1'b1;
                break;
            end
        end
        chk("R7 grant length", 32'(gc), 32'(TMO));
        chk("R8 late request ignored", 32'(ack), 32'h0);
        chk("R7 spurious flag", 32'(spurious), 32'h1);
        chk("R7 spurious vector", 32'(vec_addr), 32'(SPUR));
        chk("R7 spurious pc", 32'(new_pc), 32'(mem_f(SPUR)));
        stray_req = '0;
        run_round(30, ack, gr, gc, dn, db);
        chk("R8 next round ack", 32'(ack), 32'h080);
        chk("R8 next round vector", 32'(vec_addr), 32'(dvec(7)));
        dev_req = '0;
        repeat (3) @(negedge clk);

        // R6: held request serviced again
        cpu_pri = 3'd0;
        dev_req = 12'h001;
        run_round(30, ack, gr, gc, dn, db);
        chk("R6 first service", 32'(dn), 32'h1);
        run_round(30, ack, gr, gc, dn, db);
        chk("R6 second service", 32'(dn), 32'h1);
        chk("R6 second ack", 32'(ack), 32'h001);
        dev_req = '0;
        repeat (3) @(negedge clk);

        // R1: reset in the middle of a grant
        stray_req = 4'b0001;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (bus_grant != '0) break;
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 grant cleared by reset", 32'(bus_grant), 32'h0);
        stray_req = '0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule